// File: doc/BRIEF.md
# Zero-Crossing Window Carrier Detector

This block tells a receiver whether it is locked onto a real data signal. It does not measure signal energy. It looks only at when the data transitions arrive. The clock recovery logic beside it supplies a bit-phase count, the modulus that count currently runs at, and a one-cycle pulse for each detected data transition. When a pulse arrives, the detector places the phase value inside or outside a narrow window that straddles the point where the phase count wraps.

A saturating confidence level goes up by one for each transition inside the window and down by one for each transition outside it. The window is one eighth of the period on each side of the wrap point, so it covers a quarter of the bit period. Uncorrelated noise therefore lands outside the window three times out of four and drains the level. The carrier flag turns on only when the level reaches full scale. It turns off only when the level falls all the way to zero. This gives a wide hysteresis band.

A second, low-true copy of the flag drives the external interface pin.

Top module: `zcw_carrier_detect`

## Requirements
- R1: A transition pulse whose phase value p satisfies p < M/8 (integer division, M being the current modulus) counts as in window and raises the confidence level by one. With M = 64 this means phases 0 to 7.
- R2: A transition pulse whose phase lies outside the window lowers the level by one. With M = 64 this means phases 8 to 55. Under uniformly spread transition timing the flag ends up clear.
- R3: The confidence level is 5 bits wide and stops at 31. In-window transitions at 31 leave it at 31 and never wrap it to a low value.
- R4: The level stops at 0. Out-of-window transitions at 0 leave it at 0 and never wrap it to a high value.
- R5: The carrier flag goes high at the same clock edge at which the level becomes 31.
- R6: Once high, the flag stays high at every level from 1 to 30. It goes low at the same clock edge at which the level becomes 0.
- R7: In a cycle without a transition pulse, the level and the flag hold, whatever the phase inputs show.
- R8: The output carrierDetN is always the inverse of carrierDet.
- R9: While rstN is low, the level is cleared to 0 and the flag is cleared. This holds both at start-up and in the middle of operation.
- R10: A transition also counts as in window when p >= M - M/8, which covers the wrap across the period boundary. The window follows the modulus in use. With M = 64 the upper part is phases 56 to 63. With M = 63 the window is phases 0–6 and 56–62. With M = 65 it is phases 0–7 and 57–64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous reset, active low |
| edgeStrobe | input | 1 | One-cycle pulse per detected data transition |
| phaseCnt | input | PHASE_W (7) | Current bit-phase count from clock recovery, 0 to phaseMod-1 |
| phaseMod | input | PHASE_W (7) | Modulus the phase counter currently divides by |
| carrierDet | output | 1 | Carrier-detect flag, active high |
| carrierDetN | output | 1 | Carrier-detect flag for the external pin, active low |

## Verification
The assertions assume that whenever edgeStrobe is high, phaseCnt is below phaseMod. They also assume that phaseMod is large enough for the eighth-period window to be nonzero. The clock recovery logic guarantees both in use. The stimulus keeps within these limits: it draws the modulus only from 63, 64 and 65, and it draws phases only from 0 to modulus-1. Locked stretches bias the phases into the window and noise stretches spread them uniformly, so the level travels between both saturation stops several times.

// File: rtl/zcw_pkg.sv
package zcw_pkg;
  // Strobes from the window classifier to the confidence datapath
  typedef struct packed {
    logic bump;   // in-window transition
    logic drop;   // out-of-window transition
  } conf_strobe_t;
endpackage

// File: rtl/zcw_window_ctrl.sv
module zcw_window_ctrl
  import zcw_pkg::*;
#(
  parameter int PHASE_W   = 7,
  parameter int WIN_SHIFT = 3
) (
  input  logic               edgeStrobe,
  input  logic [PHASE_W-1:0] phaseCnt,
  input  logic [PHASE_W-1:0] phaseMod,
  output conf_strobe_t       strobes
);
  logic [PHASE_W-1:0] halfWin;
  logic [PHASE_W-1:0] upperStart;
  logic               nearLow;
  logic               nearHigh;
  logic               inWindow;

  // Half window is one eighth of the present period, on each side of the wrap
  assign halfWin    = phaseMod >> WIN_SHIFT;
  assign upperStart = phaseMod - halfWin;
  assign nearLow    = phaseCnt < halfWin;
  assign nearHigh   = phaseCnt >= upperStart;
  assign inWindow   = nearLow || nearHigh;

  always_comb begin
    strobes.bump = edgeStrobe && inWindow;
    strobes.drop = edgeStrobe && !inWindow;
  end
endmodule

// File: rtl/zcw_conf_path.sv
module zcw_conf_path
  import zcw_pkg::*;
#(
  parameter int CONF_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  conf_strobe_t      strobes,
  output logic [CONF_W-1:0] confLevel,
  output logic              carrierDet
);
  localparam logic [CONF_W-1:0] CONF_FULL  = '1;
  localparam logic [CONF_W-1:0] CONF_EMPTY = '0;

  logic [CONF_W-1:0] nextLevel;
  logic              nextFlag;

  always_comb begin
    nextLevel = confLevel;
    if (strobes.bump && confLevel != CONF_FULL)
      nextLevel = confLevel + 1'b1;
    else if (strobes.drop && confLevel != CONF_EMPTY)
      nextLevel = confLevel - 1'b1;
  end

  // Hysteresis: set only at full scale, clear only at empty
  always_comb begin
    nextFlag = carrierDet;
    if (nextLevel == CONF_FULL)
      nextFlag = 1'b1;
    else if (nextLevel == CONF_EMPTY)
      nextFlag = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      confLevel  <= CONF_EMPTY;
      carrierDet <= 1'b0;
    end else begin
      confLevel  <= nextLevel;
      carrierDet <= nextFlag;
    end
  end
endmodule

// File: rtl/zcw_carrier_detect.sv
module zcw_carrier_detect
  import zcw_pkg::*;
#(
  parameter int PHASE_W   = 7,
  parameter int CONF_W    = 5,
  parameter int WIN_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               edgeStrobe,
  input  logic [PHASE_W-1:0] phaseCnt,
  input  logic [PHASE_W-1:0] phaseMod,
  output logic               carrierDet,
  output logic               carrierDetN
);
  conf_strobe_t      strobes;
  logic [CONF_W-1:0] confLevel;

  zcw_window_ctrl #(
    .PHASE_W  (PHASE_W),
    .WIN_SHIFT(WIN_SHIFT)
  ) u_ctrl (
    .edgeStrobe(edgeStrobe),
    .phaseCnt  (phaseCnt),
    .phaseMod  (phaseMod),
    .strobes   (strobes)
  );

  zcw_conf_path #(
    .CONF_W(CONF_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .confLevel (confLevel),
    .carrierDet(carrierDet)
  );

  assign carrierDetN = ~carrierDet;
endmodule

// File: rtl/zcw_carrier_checker.sv
module zcw_carrier_checker #(
  parameter int PHASE_W = 7,
  parameter int CONF_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               edgeStrobe,
  input logic [PHASE_W-1:0] phaseCnt,
  input logic [PHASE_W-1:0] phaseMod,
  input logic [CONF_W-1:0]  confLevel,
  input logic               carrierDet,
  input logic               carrierDetN
);
  localparam logic [CONF_W-1:0] FULL = '1;
  localparam logic [CONF_W-1:0] ONE  = CONF_W'(1);

  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    edgeStrobe |-> (phaseCnt < phaseMod));                                // R1
  AST_TOP_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (confLevel == FULL) |=> (confLevel >= FULL - ONE));                   // R3
  AST_BOTTOM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (confLevel == '0) |=> (confLevel <= ONE));                            // R4
  AST_SET_AT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (confLevel == FULL) |-> carrierDet);                                  // R5
  AST_CLEAR_AT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (confLevel == '0) |-> !carrierDet);                                   // R6
  AST_DROP_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(carrierDet) |-> (confLevel == '0));                             // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !edgeStrobe |=> ($stable(confLevel) && $stable(carrierDet)));         // R7
  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    carrierDetN == !carrierDet);                                          // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (confLevel == '0 && !carrierDet));                          // R9
endmodule

bind zcw_carrier_detect zcw_carrier_checker #(
  .PHASE_W(PHASE_W),
  .CONF_W (CONF_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .edgeStrobe (edgeStrobe),
  .phaseCnt   (phaseCnt),
  .phaseMod   (phaseMod),
  .confLevel  (confLevel),
  .carrierDet (carrierDet),
  .carrierDetN(carrierDetN)
);

// File: tb/zcw_carrier_detect_bench.sv
module zcw_carrier_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEVEL_MAX  = 31;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       edgeStrobe = 1'b0;
  logic [6:0] phaseCnt = '0;
  logic [6:0] phaseMod = 7'd64;
  logic       carrierDet;
  logic       carrierDetN;

  int  checks = 0;
  int  errors = 0;
  int  mLevel = 0;
  bit  mFlag  = 1'b0;
  bit  done   = 1'b0;

  zcw_carrier_detect u_zcw_carrier_detect (
    .clk        (clk),
    .rstN       (rstN),
    .edgeStrobe (edgeStrobe),
    .phaseCnt   (phaseCnt),
    .phaseMod   (phaseMod),
    .carrierDet (carrierDet),
    .carrierDetN(carrierDetN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Window rule from R1 and R10
  function automatic bit inWin(int ph, int md);
    int half = md / 8;
    return (ph < half) || (ph >= md - half);
  endfunction

  function automatic void modelEdge(int ph, int md);
    if (inWin(ph, md)) begin
      if (mLevel < LEVEL_MAX) mLevel++;
    end else begin
      if (mLevel > 0) mLevel--;
    end
    if (mLevel == LEVEL_MAX) mFlag = 1'b1;
    else if (mLevel == 0) mFlag = 1'b0;
  endfunction

  task automatic checkBit(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at next falling edge
  task automatic cyc(input bit s, input int ph, input int md, input string tag);
    edgeStrobe = s;
    phaseCnt   = 7'(ph);
    phaseMod   = 7'(md);
    if (s) modelEdge(ph, md);
    @(negedge clk);
    checkBit(carrierDet, mFlag, tag);
    checkBit(carrierDetN, !mFlag, "R8 low-true pin");
  endtask

  task automatic doReset();
    rstN = 1'b0;
    edgeStrobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mLevel = 0;
    mFlag  = 1'b0;
    checkBit(carrierDet, 1'b0, "R9 reset flag");
    checkBit(carrierDetN, 1'b1, "R9 reset pin");
    rstN = 1'b1;
  endtask

  // Bring level to 30 then fire one probe edge: flag rises only if in window
  task automatic probe(input int ph, input int md, input bit expIn, input string tag);
    doReset();
    for (int i = 0; i < 30; i++) cyc(1'b1, 0, md, "R1 fill");
    cyc(1'b1, ph, md, tag);
    checkBit(carrierDet, expIn, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int md;
    int ph;
    bit s;
    void'($urandom(32'd5521));
    @(negedge clk);
    doReset();

    // R1/R5: 30 in-window edges leave flag low, 31st sets it
    for (int i = 0; i < 30; i++) cyc(1'b1, i % 8, 64, "R1 climb");
    checkBit(carrierDet, 1'b0, "R1 below full");
    cyc(1'b1, 63, 64, "R5 reach full");
    checkBit(carrierDet, 1'b1, "R5 set at full");

    // R3: overshoot by 5, then 30 outs must leave flag set (no wrap at top)
    for (int i = 0; i < 5; i++) cyc(1'b1, 2, 64, "R3 overshoot");
    for (int i = 0; i < 30; i++) cyc(1'b1, 30, 64, "R6 descend");
    checkBit(carrierDet, 1'b1, "R3 saturated at 31 / R6 hold at 1");

    // R7: idle cycles with in-window phase change nothing
    for (int i = 0; i < 6; i++) cyc(1'b0, 0, 64, "R7 idle");
    checkBit(carrierDet, 1'b1, "R7 idle hold");
    cyc(1'b1, 20, 64, "R6 reach empty");
    checkBit(carrierDet, 1'b0, "R6 clear at empty");

    // R4: extra outs at zero, then exactly 31 ins needed to set
    for (int i = 0; i < 7; i++) cyc(1'b1, 40, 64, "R4 undershoot");
    for (int i = 0; i < 30; i++) cyc(1'b1, 60, 64, "R4 climb");
    checkBit(carrierDet, 1'b0, "R4 no wrap at bottom");
    cyc(1'b1, 1, 64, "R5 set again");
    checkBit(carrierDet, 1'b1, "R5 set again");

    // R9: reset in the middle of operation
    doReset();

    // Window boundaries
    probe(7, 64, 1'b1, "R1 phase 7 of 64 in");
    probe(8, 64, 1'b0, "R2 phase 8 of 64 out");
    probe(55, 64, 1'b0, "R2 phase 55 of 64 out");
    probe(56, 64, 1'b1, "R10 phase 56 of 64 in");
    probe(6, 63, 1'b1, "R10 phase 6 of 63 in");
    probe(7, 63, 1'b0, "R10 phase 7 of 63 out");
    probe(55, 63, 1'b0, "R10 phase 55 of 63 out");
    probe(56, 63, 1'b1, "R10 phase 56 of 63 in");
    probe(7, 65, 1'b1, "R10 phase 7 of 65 in");
    probe(8, 65, 1'b0, "R10 phase 8 of 65 out");
    probe(56, 65, 1'b0, "R10 phase 56 of 65 out");
    probe(57, 65, 1'b1, "R10 phase 57 of 65 in");

    // Random: alternating locked and noise stretches
    doReset();
    for (int seg = 0; seg < 12; seg++) begin
      for (int i = 0; i < 250; i++) begin
        md = 63 + int'($urandom_range(2, 0));
        s  = ($urandom_range(3, 0) != 0);
        if (seg % 2 == 0 && $urandom_range(9, 0) != 0) begin
          if ($urandom_range(1, 0) == 1) ph = int'($urandom_range(md / 8 - 1, 0));
          else ph = md - 1 - int'($urandom_range(md / 8 - 1, 0));
        end else begin
          ph = int'($urandom_range(md - 1, 0));
        end
        cyc(s, ph, md, "R5 R6 R7 random model");
      end
    end
    checkBit(carrierDet, 1'b0, "R2 noise drains flag");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule